// File: doc/BRIEF.md
# Global Shutter Integration Sequencer

This block paces the exposure of a global-shutter pixel array. A free-running divider turns the system clock into a granulated enable that ticks once every 1, 2, 4 or 8 system cycles. All sequencing happens only on those ticks. A start strobe arms the sequencer. On the first tick after the strobe is released, the array enters a fixed reset phase, and an integration counter begins to count ticks. A stop strobe ends the exposure. The array then passes through a fixed stop phase and a one-tick readable phase, and the block goes back to idle.

When the integration count equals the programmed exposure value, a timeout pulse is raised for one granulated period. Software or a neighbouring block can loop that pulse back into the stop strobe, or it can use its own counter instead. The start and stop strobes must be separate signals. While either strobe is held high, the sequencer is frozen.

States and transitions. IDLE goes to RESET on the first advance after a start has been seen. RESET goes to INTEGRATE after its fourth advance, or to STOP at that same advance if a stop arrived meanwhile. INTEGRATE goes to STOP on the first advance after a stop. STOP goes to READABLE after its second advance. READABLE goes to IDLE on its next advance. An advance is a granulated tick at which both strobes are low.

Top module: `gshut_sequencer`

## Requirements
- R1: After reset, `phase_o` is 0 (idle) and `timeout_o` is 0.
- R2: `tick_o` is high for one system cycle out of every 2^`gran_i` cycles (every cycle when `gran_i` is 0).
- R3: At any clock edge where `start_i` or `stop_i` is high, the phase and its internal progress do not change.
- R4: A start seen in idle moves `phase_o` from 0 to 1 (reset) on the first advance after the strobe is low.
- R5: The reset phase lasts exactly four advances, after which `phase_o` becomes 2 (integrate).
- R6: The integration count is 1 at the entry advance and grows by one on each further advance in reset or integrate. `timeout_o` rises at the advance where the count equals `int_time_i`, so it rises (`int_time_i`−1) granulated periods after entry. A value of 0 never raises it.
- R7: `timeout_o` stays high for exactly one granulated period, even while a strobe is held.
- R8: A stop seen in integrate gives `phase_o`=3 (stop) at the next advance. Stop lasts two advances, then `phase_o`=4 (readable) for one advance, then 0.
- R9: A stop seen during reset is held and takes effect when reset completes: the phase goes 1 to 3 without ever showing 2.
- R10: A start seen outside idle does not restart the sequence. It only suspends it while it is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Start-of-exposure strobe |
| stop_i | input | 1 | End-of-exposure strobe |
| gran_i | input | GRAN_W | Granularity: divide ratio 2^gran_i |
| int_time_i | input | CNT_W | Exposure length in granulated ticks |
| phase_o | output | 3 | Phase: 0 idle, 1 reset, 2 integrate, 3 stop, 4 readable |
| timeout_o | output | 1 | One-period pulse when the count reaches int_time_i |
| tick_o | output | 1 | Granulated clock enable |

## Verification
The assertions assume the following about the inputs: the strobes change only between rising edges, the granularity changes only while idle, and the start and stop strobes are never the same wire. The bench drives every input on the falling edge. It holds the granularity and exposure value fixed for each whole episode. It places external stops only after the reset entry has certainly happened, and when the timeout is looped back to stop it uses a nonzero exposure value, so that every episode ends back in idle.

// File: rtl/gshut_pkg.sv
package gshut_pkg;
    typedef enum logic [2:0] {
        PH_IDLE  = 3'd0,
        PH_RESET = 3'd1,
        PH_INTEG = 3'd2,
        PH_STOP  = 3'd3,
        PH_READY = 3'd4
    } phase_e;
endpackage

// File: rtl/gshut_tick_gen.sv
module gshut_tick_gen #(
    parameter int GRAN_W = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [GRAN_W-1:0] gran_i,
    output logic              tick_o
);
    localparam int DIV_W = (1 << GRAN_W) - 1;

    logic [DIV_W-1:0] cnt_q;
    logic [DIV_W-1:0] lim;

    // thermometer limit: 2^gran - 1
    always_comb begin
        lim = '0;
        for (int i = 0; i < DIV_W; i++) begin
            lim[i] = (i < int'(gran_i));
        end
    end

    assign tick_o = (cnt_q >= lim);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (tick_o) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + DIV_W'(1);
        end
    end

    // R2: undivided setting ticks every cycle
    a_r2_full_rate: assert property (@(posedge clk) disable iff (!rst_n)
        (gran_i == '0) |-> tick_o);

    // R2: a divided tick never repeats on the next cycle at a fixed setting
    a_r2_single_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        (tick_o && gran_i != '0) |=> (!tick_o || gran_i != $past(gran_i)));
endmodule

// File: rtl/gshut_phase_fsm.sv
module gshut_phase_fsm
    import gshut_pkg::*;
#(
    parameter int RST_TICKS  = 4,
    parameter int STOP_TICKS = 2
) (
    input  logic   clk,
    input  logic   rst_n,
    input  logic   tick_i,
    input  logic   start_i,
    input  logic   stop_i,
    output phase_e phase_o,
    output logic   enter_o,
    output logic   run_o
);
    localparam int MAXT      = (RST_TICKS > STOP_TICKS) ? RST_TICKS : STOP_TICKS;
    localparam int SUB_W     = $clog2(MAXT + 1);
    localparam int RST_LAST  = RST_TICKS - 1;
    localparam int STOP_LAST = STOP_TICKS - 1;

    phase_e           ph_q, ph_d;
    logic [SUB_W-1:0] sub_q, sub_d;
    logic             sarm_q, sarm_d;
    logic             parm_q, parm_d;
    logic             adv;

    assign adv = tick_i && !start_i && !stop_i;

    // next state
    always_comb begin
        ph_d   = ph_q;
        sub_d  = sub_q;
        sarm_d = sarm_q || (start_i && ph_q == PH_IDLE);
        parm_d = parm_q || (stop_i && (ph_q == PH_RESET || ph_q == PH_INTEG));
        if (adv) begin
            unique case (ph_q)
                PH_IDLE: begin
                    if (sarm_q) begin
                        ph_d   = PH_RESET;
                        sub_d  = '0;
                        sarm_d = 1'b0;
                    end
                end
                PH_RESET: begin
                    if (sub_q == SUB_W'(RST_LAST)) begin
                        sub_d = '0;
                        if (parm_q) begin
                            ph_d   = PH_STOP;
                            parm_d = 1'b0;
                        end else begin
                            ph_d = PH_INTEG;
                        end
                    end else begin
                        sub_d = sub_q + SUB_W'(1);
                    end
                end
                PH_INTEG: begin
                    if (parm_q) begin
                        ph_d   = PH_STOP;
                        sub_d  = '0;
                        parm_d = 1'b0;
                    end
                end
                PH_STOP: begin
                    if (sub_q == SUB_W'(STOP_LAST)) begin
                        ph_d  = PH_READY;
                        sub_d = '0;
                    end else begin
                        sub_d = sub_q + SUB_W'(1);
                    end
                end
                PH_READY: begin
                    ph_d = PH_IDLE;
                end
                default: begin
                    ph_d = PH_IDLE;
                end
            endcase
        end
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ph_q   <= PH_IDLE;
            sub_q  <= '0;
            sarm_q <= 1'b0;
            parm_q <= 1'b0;
        end else begin
            ph_q   <= ph_d;
            sub_q  <= sub_d;
            sarm_q <= sarm_d;
            parm_q <= parm_d;
        end
    end

    // outputs
    always_comb begin
        phase_o = ph_q;
        enter_o = adv && ph_q == PH_IDLE && sarm_q;
        run_o   = adv && (ph_q == PH_RESET || ph_q == PH_INTEG);
    end

    // R3: a held strobe freezes the sequencer
    a_r3_freeze: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i || stop_i) |=> (ph_q == $past(ph_q) && sub_q == $past(sub_q)));

    // R5 / R9: reset only leaves toward integrate or stop
    a_r9_reset_exit: assert property (@(posedge clk) disable iff (!rst_n)
        (ph_q == PH_RESET) |=> (ph_q inside {PH_RESET, PH_INTEG, PH_STOP}));

    // R10: a start during integrate never re-enters reset
    a_r10_no_restart: assert property (@(posedge clk) disable iff (!rst_n)
        (ph_q == PH_INTEG) |=> (ph_q inside {PH_INTEG, PH_STOP}));

    // R8: readable only returns to idle
    a_r8_ready_exit: assert property (@(posedge clk) disable iff (!rst_n)
        (ph_q == PH_READY) |=> (ph_q inside {PH_READY, PH_IDLE}));
endmodule

// File: rtl/gshut_int_counter.sv
module gshut_int_counter #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick_i,
    input  logic             enter_i,
    input  logic             run_i,
    input  logic [CNT_W-1:0] limit_i,
    output logic             timeout_o
);
    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] nxt;
    logic             bump;
    logic             hit;
    logic             to_q;

    assign bump = run_i && !(&cnt_q);
    assign nxt  = enter_i ? CNT_W'(1) : cnt_q + CNT_W'(1);
    assign hit  = (enter_i || bump) && (nxt == limit_i) && (limit_i != '0);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
            to_q  <= 1'b0;
        end else begin
            if (enter_i || bump) begin
                cnt_q <= nxt;
            end
            if (hit) begin
                to_q <= 1'b1;
            end else if (tick_i) begin
                to_q <= 1'b0;
            end
        end
    end

    assign timeout_o = to_q;

    // R7: the pulse ends at the next granulated tick
    a_r7_timeout_one: assert property (@(posedge clk) disable iff (!rst_n)
        (to_q && tick_i) |=> !to_q);

    // R6: a zero exposure value never raises a timeout
    a_r6_zero_silent: assert property (@(posedge clk) disable iff (!rst_n)
        (!to_q && limit_i == '0) |=> !to_q);

    // R6: the count never moves backward while running
    a_r6_monotonic: assert property (@(posedge clk) disable iff (!rst_n)
        (run_i && !enter_i) |=> (cnt_q >= $past(cnt_q)));
endmodule

// File: rtl/gshut_sequencer.sv
module gshut_sequencer
    import gshut_pkg::*;
#(
    parameter int GRAN_W     = 2,
    parameter int CNT_W      = 16,
    parameter int RST_TICKS  = 4,
    parameter int STOP_TICKS = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic              stop_i,
    input  logic [GRAN_W-1:0] gran_i,
    input  logic [CNT_W-1:0]  int_time_i,
    output logic [2:0]        phase_o,
    output logic              timeout_o,
    output logic              tick_o
);
    logic   tick;
    logic   enter;
    logic   run;
    phase_e phase;

    gshut_tick_gen #(.GRAN_W(GRAN_W)) u_tick (
        .clk    (clk),
        .rst_n  (rst_n),
        .gran_i (gran_i),
        .tick_o (tick)
    );

    gshut_phase_fsm #(.RST_TICKS(RST_TICKS), .STOP_TICKS(STOP_TICKS)) u_fsm (
        .clk     (clk),
        .rst_n   (rst_n),
        .tick_i  (tick),
        .start_i (start_i),
        .stop_i  (stop_i),
        .phase_o (phase),
        .enter_o (enter),
        .run_o   (run)
    );

    gshut_int_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick_i    (tick),
        .enter_i   (enter),
        .run_i     (run),
        .limit_i   (int_time_i),
        .timeout_o (timeout_o)
    );

    assign phase_o = phase;
    assign tick_o  = tick;

    // R4: reset is only entered from idle
    a_r4_entry: assert property (@(posedge clk) disable iff (!rst_n)
        (phase != PH_IDLE && phase != PH_RESET) |=> (phase != PH_RESET));
endmodule

// File: tb/tb_gshut_sequencer.sv
module tb_gshut_sequencer;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_i = 1'b0;
    logic        stop_i = 1'b0;
    logic [1:0]  gran_i = 2'd0;
    logic [15:0] int_time_i = 16'd0;
    logic [2:0]  phase_o;
    logic        timeout_o;
    logic        tick_o;

    gshut_sequencer dut (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .stop_i(stop_i),
        .gran_i(gran_i), .int_time_i(int_time_i),
        .phase_o(phase_o), .timeout_o(timeout_o), .tick_o(tick_o)
    );

    always #5 clk = ~clk;

    int total = 0;
    int bad = 0;
    int cyc_no = 0;
    bit tie = 0;
    int cfg_g = 0;
    int cfg_it = 0;

    // reference model state
    int m_div, m_ph, m_sub, m_cnt, m_to, m_sarm, m_parm;
    // episode observations
    int hist[5];
    int ep_to, ep_ticks, first_rst, first_to;

    function automatic int lim_of(int g);
        return (1 << g) - 1;
    endfunction

    task automatic chk(bit ok, string tag, int got, int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s got %0d exp %0d at cycle %0d", tag, got, exp, cyc_no);
        end
    endtask

    task automatic model_reset();
        m_div = 0; m_ph = 0; m_sub = 0; m_cnt = 0;
        m_to = 0; m_sarm = 0; m_parm = 0;
    endtask

    // advance the reference by one rising edge using the current inputs
    task automatic model_step();
        int t, adv, enter, run, nc, bumped, hit;
        int ph_n, sub_n, sarm_n, parm_n;
        if (!rst_n) begin
            model_reset();
            return;
        end
        t      = (m_div >= lim_of(int'(gran_i)));
        adv    = t && !start_i && !stop_i;
        sarm_n = m_sarm | (start_i && m_ph == 0);
        parm_n = m_parm | (stop_i && (m_ph == 1 || m_ph == 2));
        ph_n   = m_ph;
        sub_n  = m_sub;
        enter  = adv && m_ph == 0 && m_sarm;
        run    = adv && (m_ph == 1 || m_ph == 2);
        if (adv) begin
            case (m_ph)
                0: if (m_sarm) begin ph_n = 1; sub_n = 0; sarm_n = 0; end
                1: if (m_sub == 3) begin
                       sub_n = 0;
                       if (m_parm) begin ph_n = 3; parm_n = 0; end
                       else ph_n = 2;
                   end else sub_n = m_sub + 1;
                2: if (m_parm) begin ph_n = 3; sub_n = 0; parm_n = 0; end
                3: if (m_sub == 1) begin ph_n = 4; sub_n = 0; end
                   else sub_n = m_sub + 1;
                default: ph_n = 0;
            endcase
        end
        bumped = run && m_cnt < 65535;
        nc  = enter ? 1 : (bumped ? m_cnt + 1 : m_cnt);
        hit = (enter || bumped) && nc == int'(int_time_i) && int_time_i != 0;
        m_to   = hit ? 1 : (t ? 0 : m_to);
        m_cnt  = nc;
        m_div  = t ? 0 : m_div + 1;
        m_ph   = ph_n; m_sub = sub_n; m_sarm = sarm_n; m_parm = parm_n;
    endtask

    // one system cycle: compare, record, drive, then step the model
    task automatic cyc(bit s, bit p);
        @(negedge clk);
        cyc_no++;
        if (rst_n) begin
            chk(int'(phase_o) == m_ph, "phase R3 R4 R5 R8 R9 R10", int'(phase_o), m_ph);
            chk(int'(timeout_o) == m_to, "timeout R6 R7", int'(timeout_o), m_to);
            chk(int'(tick_o) == (m_div >= lim_of(int'(gran_i))), "tick R2",
                int'(tick_o), int'(m_div >= lim_of(int'(gran_i))));
            if (phase_o <= 3'd4) hist[phase_o]++;
            if (timeout_o) begin
                ep_to++;
                if (first_to < 0) first_to = cyc_no;
            end
            if (tick_o) ep_ticks++;
            if (phase_o == 3'd1 && first_rst < 0) first_rst = cyc_no;
        end
        gran_i     = 2'(cfg_g);
        int_time_i = 16'(cfg_it);
        start_i    = s;
        stop_i     = p | (tie & timeout_o);
        model_step();
    endtask

    task automatic clear_ep();
        for (int i = 0; i < 5; i++) hist[i] = 0;
        ep_to = 0; ep_ticks = 0; first_rst = -1; first_to = -1;
    endtask

    // one exposure; mode 0 external stop, mode 1 timeout looped to stop
    task automatic episode(int g, int it, int sw, int stop_at, int mode, int xstart);
        bit done;
        cfg_g = g; cfg_it = it;
        cyc(0, 0);
        clear_ep();
        tie = (mode == 1);
        for (int i = 0; i < sw; i++) cyc(1, 0);
        done = 0;
        for (int k = 0; k < 4000 && !done; k++) begin
            cyc(k == xstart, mode == 0 && k == stop_at);
            if (hist[4] > 0 && phase_o == 3'd0 && k > xstart) done = 1;
        end
        tie = 0;
        chk(done, "episode end R8", int'(done), 1);
        cyc(0, 0);
    endtask

    initial begin
        void'($urandom(32'd4242));
        model_reset();
        clear_ep();
        repeat (3) cyc(0, 0);
        rst_n = 1'b1;
        cyc(0, 0);
        // R1: reset state
        chk(phase_o == 3'd0, "R1 phase after reset", int'(phase_o), 0);
        chk(timeout_o == 1'b0, "R1 timeout after reset", int'(timeout_o), 0);

        // R2: divide by 8 gives 4 ticks in 32 cycles
        cfg_g = 3;
        cyc(0, 0);
        clear_ep();
        repeat (32) cyc(0, 0);
        chk(ep_ticks == 4, "R2 tick count at ratio 8", ep_ticks, 4);

        // R5 R7 R8: divide by 2, external stop
        episode(1, 3, 1, 40, 0, -1);
        chk(hist[1] == 8, "R5 reset cycles", hist[1], 8);
        chk(ep_to == 2, "R7 timeout width", ep_to, 2);
        chk(hist[3] == 4, "R8 stop cycles", hist[3], 4);
        chk(hist[4] == 2, "R8 readable cycles", hist[4], 2);

        // R9: stop during reset is deferred, integrate never shown
        episode(0, 0, 1, 1, 0, -1);
        chk(hist[2] == 0, "R9 integrate skipped", hist[2], 0);
        chk(hist[3] == 2, "R9 stop cycles", hist[3], 2);
        chk(hist[1] >= 4, "R9 reset completed", hist[1], 4);

        // R10: start during integrate; R6 zero exposure silent
        episode(0, 0, 2, 30, 0, 15);
        chk(hist[1] == 4, "R10 no second reset", hist[1], 4);
        chk(ep_to == 0, "R6 zero exposure no timeout", ep_to, 0);

        // R6 R7: timeout looped back to stop at divide by 4
        episode(2, 10, 3, 0, 1, -1);
        chk(first_to - first_rst == 36, "R6 timeout delay", first_to - first_rst, 36);
        chk(ep_to == 4, "R7 timeout width while held", ep_to, 4);
        chk(hist[4] == 4, "R8 readable after looped stop", hist[4], 4);

        // random episodes against the reference
        for (int e = 0; e < 40; e++) begin
            int g, it, mode, sw, sa, xs;
            g    = int'($urandom_range(0, 3));
            mode = int'($urandom_range(0, 1));
            it   = int'($urandom_range(mode == 1 ? 1 : 0, 12));
            sw   = int'($urandom_range(1, 4));
            sa   = int'($urandom_range(12, 70));
            xs   = ($urandom_range(0, 1) == 1) ? int'($urandom_range(0, 60)) : -1;
            episode(g, it, sw, sa, mode, xs);
        end

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        bad++;
        total++;
        $display("FAIL watchdog R8 got %0d exp %0d", cyc_no, 0);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule